// File: doc/BRIEF.md
# Indexed-Port Watchdog with Keyed Access

This block is a countdown watchdog that software reaches through two byte-wide ports: an index port that selects a configuration register and a data port that reads or writes it. Configuration space is closed after reset. It opens only when the key byte 0x87 is written to the index port on two index writes in a row. Writing 0xAA to the index port closes it again. Once it is open, software selects the watchdog page by writing 0x08 to the page register (index 0x07). On that page it can set the enable bit, the count unit, the 8-bit timeout count and a mask of input events that restart the count.

The count decrements once per tick while the watchdog is enabled. A tick is one second or one minute, taken from a free-running prescaler whose lengths are parameters. When the count reaches zero the `timeout` output rises and stays high until software rewrites the count or disables the watchdog. Keyboard or mouse activity, when its mask bit is set, reloads the count from the value last written to the count register. Such activity on a live machine therefore keeps the watchdog from firing.

Top module: `idx_wdog`

## Requirements
- R1: After reset the block is closed, both ports read 0xFF, `timeout` is low, and every register on the watchdog page is zero.
- R2: While the block is closed, data-port writes change no register, and both the index port and the data port read 0xFF.
- R3: The block opens only after two index writes of 0x87 with no other index write between them. Any other index value restarts the sequence. Once the block is open, the index port reads back the current index.
- R4: An index write of 0xAA while the block is open closes it. Register contents are kept, and the index value in use before the close stays selected.
- R5: The page register (index 0x07) can be read and written whenever the block is open. The registers at 0x30, 0xF5, 0xF6 and 0xF7 read 0x00 and ignore writes unless the page register holds 0x08.
- R6: On the watchdog page, index 0x30 bit 0 is the enable, index 0xF5 bit 3 is the unit (0 = seconds, 1 = minutes), and index 0xF7 bit 6 masks in keyboard events and bit 7 masks in mouse events. All other bits of these registers read 0.
- R7: Index 0xF6 reads the live count. Writing it sets both the count and the reload value. The count drops by one per tick only while the watchdog is enabled, and it holds while the watchdog is disabled.
- R8: With N written to the count in seconds mode, `timeout` rises between (N-1)·T+1 and N·T clocks after the write, where T is the number of clocks per second.
- R9: `timeout` stays high until the count is rewritten or the enable bit is cleared. Clearing the enable bit drops it at the same clock edge.
- R10: In minutes mode a tick occurs every SEC_PER_MIN seconds, so the window in R8 scales by SEC_PER_MIN.
- R11: A keyboard or mouse event whose mask bit is set reloads the count from the last written value. An event whose mask bit is clear has no effect.
- R12: An unmasked event in the same cycle as a tick wins: the count is reloaded, not decremented.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 8 | Port address (index port 0x2E, data port 0x2F) |
| wr_en | input | 1 | Write strobe for the addressed port |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data of the addressed port (combinational) |
| kbd_evt | input | 1 | Keyboard activity event |
| mouse_evt | input | 1 | Mouse activity event |
| timeout | output | 1 | Watchdog expired |

## Verification
The prescaler tick and a masked activity reload can land in the same cycle, and the reload must win. The bench cannot predict the prescaler phase, so it holds a masked event high across many ticks with the count set to 1. Every tick then coincides with a reload. The run passes only if `timeout` never rises and the count still reads 1. A design that let the tick win would reach zero and fire.

// File: rtl/idx_wdog.sv
module idx_wdog #(
  parameter logic [7:0] IDX_PORT      = 8'h2E,
  parameter logic [7:0] DAT_PORT      = 8'h2F,
  parameter int         TICKS_PER_SEC = 1000,
  parameter int         SEC_PER_MIN   = 60
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] addr,
  input  logic       wr_en,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic       kbd_evt,
  input  logic       mouse_evt,
  output logic       timeout
);
  localparam int PW = $clog2(TICKS_PER_SEC + 1);
  localparam int MW = $clog2(SEC_PER_MIN + 1);
  localparam logic [7:0] KEY_OPEN  = 8'h87;
  localparam logic [7:0] KEY_CLOSE = 8'hAA;
  localparam logic [7:0] R_PAGE    = 8'h07;
  localparam logic [7:0] WD_PAGE   = 8'h08;
  localparam logic [7:0] R_EN      = 8'h30;
  localparam logic [7:0] R_UNIT    = 8'hF5;
  localparam logic [7:0] R_CNT     = 8'hF6;
  localparam logic [7:0] R_MASK    = 8'hF7;

  typedef enum logic [1:0] {S_LOCK, S_HALF, S_OPEN} st_t;
  st_t st;

  logic [7:0]    idx, page, cnt, reload;
  logic          en, unit, kmask, mmask, tmo_q;
  logic [PW-1:0] pre;
  logic [MW-1:0] mins;

  wire idx_wr   = wr_en && addr == IDX_PORT;
  wire dat_wr   = wr_en && addr == DAT_PORT && st == S_OPEN;
  wire on_page  = page == WD_PAGE;
  wire reg_wr   = dat_wr && on_page;
  wire cnt_wr   = reg_wr && idx == R_CNT;
  wire en_off   = reg_wr && idx == R_EN && !wdata[0];
  wire evt_hit  = (kbd_evt && kmask) || (mouse_evt && mmask);
  wire sec_tick = pre == PW'(TICKS_PER_SEC - 1);
  wire min_tick = sec_tick && mins == MW'(SEC_PER_MIN - 1);
  wire tick     = unit ? min_tick : sec_tick;
  wire dec      = en && tick && cnt != 8'd0 && !cnt_wr && !evt_hit;

  assign timeout = tmo_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre  <= '0;
      mins <= '0;
    end else begin
      pre <= sec_tick ? '0 : pre + PW'(1);
      if (sec_tick) mins <= min_tick ? '0 : mins + MW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= S_LOCK;
      idx <= 8'h00;
    end else if (idx_wr) begin
      case (st)
        S_LOCK:  st <= (wdata == KEY_OPEN) ? S_HALF : S_LOCK;
        S_HALF:  st <= (wdata == KEY_OPEN) ? S_OPEN : S_LOCK;
        default: if (wdata == KEY_CLOSE) st <= S_LOCK; else idx <= wdata;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      page  <= 8'h00;
      en    <= 1'b0;
      unit  <= 1'b0;
      kmask <= 1'b0;
      mmask <= 1'b0;
    end else begin
      if (dat_wr && idx == R_PAGE) page <= wdata;
      if (reg_wr) begin
        case (idx)
          R_EN:    en <= wdata[0];
          R_UNIT:  unit <= wdata[3];
          R_MASK:  {mmask, kmask} <= wdata[7:6];
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= 8'h00;
      reload <= 8'h00;
      tmo_q  <= 1'b0;
    end else begin
      if (cnt_wr) begin
        cnt    <= wdata;
        reload <= wdata;
      end else if (evt_hit) begin
        cnt <= reload;
      end else if (dec) begin
        cnt <= cnt - 8'd1;
      end
      if (cnt_wr || evt_hit || !en || en_off) tmo_q <= 1'b0;
      else if (dec && cnt == 8'd1)             tmo_q <= 1'b1;
    end
  end

  always_comb begin
    rdata = 8'hFF;
    if (st == S_OPEN) begin
      if (addr == IDX_PORT) rdata = idx;
      else if (addr == DAT_PORT) begin
        rdata = 8'h00;
        if (idx == R_PAGE) rdata = page;
        else if (on_page) begin
          case (idx)
            R_EN:    rdata = {7'b0, en};
            R_UNIT:  rdata = {4'b0, unit, 3'b0};
            R_CNT:   rdata = cnt;
            R_MASK:  rdata = {mmask, kmask, 6'b0};
            default: rdata = 8'h00;
          endcase
        end
      end
    end
  end

  AST_LOCKED_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == DAT_PORT && st != S_OPEN) |=> $stable({page, en, unit, kmask, mmask, reload})); // R2
  AST_NO_SINGLE_KEY: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_LOCK) |=> (st != S_OPEN)); // R3
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_wr && !evt_hit) |=> (cnt == $past(cnt) || cnt == $past(cnt) - 8'd1)); // R7
  AST_TMO_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |-> cnt == 8'd0); // R8
  AST_TMO_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |-> en); // R9
  AST_EVT_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_hit && !cnt_wr) |=> cnt == $past(reload)); // R12
endmodule

// File: tb/idx_wdog_tb.sv
module idx_wdog_tb;
  localparam int TPS = 4;
  localparam int SPM = 3;
  localparam logic [7:0] IX = 8'h2E;
  localparam logic [7:0] DT = 8'h2F;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] addr = 8'h00;
  logic       wr_en = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       kbd_evt = 1'b0;
  logic       mouse_evt = 1'b0;
  logic       timeout;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct { logic [7:0] lo; logic [7:0] hi; string tag; } item_t;
  item_t sb[$];
  event mon_ev;

  always #4 clk = ~clk;

  idx_wdog #(.TICKS_PER_SEC(TPS), .SEC_PER_MIN(SPM)) u_dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wdata(wdata),
    .rdata(rdata), .kbd_evt(kbd_evt), .mouse_evt(mouse_evt), .timeout(timeout));

  always begin
    @(mon_ev);
    while (sb.size() > 0) begin
      item_t it;
      it = sb.pop_front();
      checks++;
      if (rdata < it.lo || rdata > it.hi) begin
        errors++;
        $display("FAIL %s: rdata=%02h expected %02h..%02h", it.tag, rdata, it.lo, it.hi);
      end
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic expect_rd(input logic [7:0] a, input logic [7:0] lo, input logic [7:0] hi, input string tag);
    item_t it;
    @(negedge clk);
    addr = a;
    #2;
    it.lo = lo; it.hi = hi; it.tag = tag;
    sb.push_back(it);
    ->mon_ev;
  endtask

  task automatic set_reg(input logic [7:0] i, input logic [7:0] d);
    wr(IX, i);
    wr(DT, d);
  endtask

  task automatic wait_tmo(input int lo, input int hi, input string tag);
    int c = 0;
    while (!timeout && c < hi + 5) begin
      @(negedge clk);
      c++;
    end
    check(timeout && c >= lo && c <= hi, tag, c, hi);
  endtask

  task automatic hold_quiet(input int n, input string tag);
    bit seen = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (timeout) seen = 1;
    end
    check(!seen, tag, seen, 0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=hung expected=finished");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    check(timeout == 1'b0, "R1 timeout low after reset", timeout, 0);
    expect_rd(IX, 8'hFF, 8'hFF, "R1 index port closed");
    expect_rd(DT, 8'hFF, 8'hFF, "R1 data port closed");

    wr(DT, 8'h55);
    wr(IX, 8'h87); wr(IX, 8'h12); wr(IX, 8'h87);
    expect_rd(IX, 8'hFF, 8'hFF, "R3 interrupted key keeps closed");
    wr(IX, 8'h87);
    expect_rd(IX, 8'h00, 8'h00, "R3 open, index reads back");
    wr(IX, 8'h07);
    expect_rd(IX, 8'h07, 8'h07, "R3 index readback");
    expect_rd(DT, 8'h00, 8'h00, "R1 page register zero");

    set_reg(8'h30, 8'h01);
    expect_rd(DT, 8'h00, 8'h00, "R5 off-page read zero");
    set_reg(8'h07, 8'h08);
    expect_rd(DT, 8'h08, 8'h08, "R5 page select");
    wr(IX, 8'h30);
    expect_rd(DT, 8'h00, 8'h00, "R5 off-page write ignored");
    wr(DT, 8'hFF);
    expect_rd(DT, 8'h01, 8'h01, "R6 enable field");
    set_reg(8'hF5, 8'hFF);
    expect_rd(DT, 8'h08, 8'h08, "R6 unit field");
    set_reg(8'hF7, 8'hFF);
    expect_rd(DT, 8'hC0, 8'hC0, "R6 mask fields");
    set_reg(8'hF7, 8'h00);
    set_reg(8'hF5, 8'h00);
    set_reg(8'h30, 8'h00);

    set_reg(8'hF6, 8'h33);
    wr(IX, 8'hAA);
    expect_rd(DT, 8'hFF, 8'hFF, "R4 data reads FF after close");
    expect_rd(IX, 8'hFF, 8'hFF, "R2 index reads FF while closed");
    wr(DT, 8'h77);
    wr(IX, 8'h87); wr(IX, 8'h87);
    expect_rd(DT, 8'h33, 8'h33, "R2 closed write ignored, R4 contents kept");
    repeat (30) @(negedge clk);
    expect_rd(DT, 8'h33, 8'h33, "R7 count holds while disabled");

    wr(DT, 8'd200);
    set_reg(8'h30, 8'h01);
    wr(IX, 8'hF6);
    repeat (40) @(negedge clk);
    expect_rd(DT, 8'd188, 8'd192, "R7 count decrements per tick");

    set_reg(8'h30, 8'h00);
    set_reg(8'hF6, 8'd3);
    set_reg(8'h30, 8'h01);
    wait_tmo(2 * TPS + 1, 3 * TPS, "R8 seconds timeout window N=3");
    repeat (20) @(negedge clk);
    check(timeout == 1'b1, "R9 timeout sticks", timeout, 1);
    wr(DT, 8'h00);
    check(timeout == 1'b0, "R9 disable clears timeout", timeout, 0);
    wr(DT, 8'h01);
    set_reg(8'hF6, 8'd2);
    wait_tmo(TPS + 1, 2 * TPS, "R8 seconds timeout window N=2");
    wr(DT, 8'd9);
    check(timeout == 1'b0, "R9 rewrite clears timeout", timeout, 0);

    set_reg(8'hF5, 8'h08);
    set_reg(8'hF6, 8'd2);
    wait_tmo(TPS * SPM + 1, 2 * TPS * SPM, "R10 minutes timeout window");
    set_reg(8'hF5, 8'h00);

    set_reg(8'hF7, 8'h40);
    set_reg(8'hF6, 8'd10);
    check(timeout == 1'b0, "R9 count write clears timeout", timeout, 0);
    repeat (12) @(negedge clk);
    expect_rd(DT, 8'd6, 8'd8, "R7 partial countdown");
    @(negedge clk);
    kbd_evt = 1'b1;
    expect_rd(DT, 8'd10, 8'd10, "R11 keyboard reload");
    kbd_evt = 1'b0;

    mouse_evt = 1'b1;
    wr(DT, 8'd1);
    repeat (2 * TPS) @(negedge clk);
    check(timeout == 1'b1, "R11 unmasked mouse has no effect", timeout, 1);
    mouse_evt = 1'b0;

    kbd_evt = 1'b1;
    wr(DT, 8'd1);
    hold_quiet(10 * TPS, "R12 reload wins over tick (keyboard)");
    expect_rd(DT, 8'd1, 8'd1, "R12 count stays reloaded");
    kbd_evt = 1'b0;

    set_reg(8'hF7, 8'h80);
    wr(IX, 8'hF6);
    mouse_evt = 1'b1;
    wr(DT, 8'd1);
    hold_quiet(10 * TPS, "R11 masked mouse keeps watchdog alive");
    expect_rd(DT, 8'd1, 8'd1, "R11 mouse reload value");
    mouse_evt = 1'b0;

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule